// File: doc/BRIEF.md
# Nested Three-Level Vectored Interrupt Arbiter

This block sits between a set of peripheral interrupt flags and a CPU core. Twenty-seven request sources are folded onto ten vectors by fixed OR groups. Each vector has its own enable bit and a level-select bit. The arbiter picks one winning vector. When the CPU can take it, the arbiter issues a one-cycle take strobe with the 17-bit entry address of that vector.

Nesting works by keeping a set of in-service flags, one for each priority level. A new request is accepted only when its level is strictly above every level already in service. A return-from-interrupt pulse retires the highest active level. Two wake-up outputs let a clock controller leave its low-power states. One releases a halted core when an interrupt could be accepted. The other releases a stopped core when any enabled request arrives on the vectors that may wake it.

Top module: `irq_arbiter`

## Requirements
- R1: Sources are grouped onto vectors by consecutive source index, with group sizes 1,1,3,4,2,3,3,3,3,4 for vectors 0 to 9. Sources 0 | 1 | 2-4 | 5-8 | 9-10 | 11-13 | 14-16 | 17-19 | 20-22 | 23-26 therefore map to vectors 0 to 9. Any source in a group raises that vector's request.
- R2: The entry address of vector index i is 3 + 8*i, giving 0x03, 0x0B, 0x13 and so on up to 0x4B.
- R3: With `vec_hi[i]`=1, vectors 0 and 1 take the top level X and vectors 2 to 9 take level H. With `vec_hi[i]`=0, any vector takes level L. In `in_service`, bit 0 is L, bit 1 is H and bit 2 is X.
- R4: Among pending vectors, the highest level wins. Equal levels go to the smallest vector index.
- R5: The winner is accepted only if its level is strictly above the highest in-service level. A winner at the same or a lower level is held back.
- R6: Nothing is accepted while `gie`=0. A vector whose `vec_en` bit is 0 is never pending and cannot win.
- R7: An accept decided at a clock edge gives `take`=1 for exactly that following cycle, together with the new `vec_addr`. `vec_addr` holds its value while `take`=0. No accept occurs in a cycle where `take` is already 1.
- R8: Each take sets the in-service bit of the accepted level.
- R9: A `reti` pulse clears the highest set in-service bit. It has no effect when none is set. No accept occurs in a cycle where `reti`=1.
- R10: Nothing is accepted while `cpu_ready`=0. The pending winner stays pending.
- R11: `wake_halt` is combinational and equals `gie` AND (a winner exists) AND (the winner's level is above the in-service level). It does not depend on `cpu_ready`.
- R12: `wake_stop` is combinational. It is 1 when any enabled vector in the stop-wake set {0,1,2,3,9} has a request, regardless of `gie`.
- R13: During reset, `take`, `vec_addr` and `in_service` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 27 | Peripheral request flags |
| vec_en | input | 10 | Per-vector enable |
| vec_hi | input | 10 | Per-vector upper-level select |
| gie | input | 1 | Global interrupt enable |
| cpu_ready | input | 1 | Core is at a point where it can accept |
| reti | input | 1 | Return-from-interrupt pulse |
| take | output | 1 | One-cycle accept strobe |
| vec_addr | output | 17 | Entry address of the accepted vector |
| in_service | output | 3 | Active levels {X,H,L} |
| wake_halt | output | 1 | An interrupt is acceptable now |
| wake_stop | output | 1 | Enabled stop-wake request present |

## Verification
The bound checker watches several rules on every cycle:
- the strobe is a single pulse and the address holds between takes;
- every take lands on the address grid;
- each take adds exactly one in-service level and each `reti` removes one;
- the top level is entered only from the first two vectors;
- every take was preceded by an enabled, ready, halt-wake condition.

Some behaviour only the bench scenarios can show, because it needs a reference for the winner. This includes the choice between simultaneous requests of equal or different levels, blocking at an equal level, the source-to-vector grouping, and the wake-up outputs. The bench compares these against a cycle model under directed nesting sequences and long random runs.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [1:0] {
    LV_NONE = 2'd0,
    LV_L    = 2'd1,
    LV_H    = 2'd2,
    LV_X    = 2'd3
  } lvl_e;

  localparam int unsigned LVL_N = 3;
  localparam int unsigned GRP_N = 10;

  // number of consecutive sources folded onto each vector
  function automatic int unsigned grp_size(input int unsigned v);
    case (v)
      0, 1:          grp_size = 1;
      2:             grp_size = 3;
      3:             grp_size = 4;
      4:             grp_size = 2;
      5, 6, 7, 8:    grp_size = 3;
      9:             grp_size = 4;
      default:       grp_size = 0;
    endcase
  endfunction

  // vector index that a source belongs to (GRP_N when none)
  function automatic int unsigned src_vec(input int unsigned s);
    int unsigned lo;
    lo = 0;
    src_vec = GRP_N;
    for (int unsigned v = 0; v < GRP_N; v++) begin
      if (s >= lo && s < lo + grp_size(v)) src_vec = v;
      lo = lo + grp_size(v);
    end
  endfunction

  function automatic logic [LVL_N-1:0] lvl_bit(input lvl_e l);
    case (l)
      LV_L:    lvl_bit = 3'b001;
      LV_H:    lvl_bit = 3'b010;
      LV_X:    lvl_bit = 3'b100;
      default: lvl_bit = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/irq_group.sv
module irq_group #(
  parameter int NUM_SRC = 27,
  parameter int NUM_VEC = 10
) (
  input  logic [NUM_SRC-1:0] src_req,
  output logic [NUM_VEC-1:0] vec_req
);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic [NUM_SRC-1:0] member;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign member[s] = (irq_arb_pkg::src_vec(s) == v);
    end
    assign vec_req[v] = |(src_req & member);
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_VEC  = 10,
  parameter int NUM_XCAP = 2,
  localparam int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] req,
  input  logic [NUM_VEC-1:0] hi,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_e               win_lvl
);

  lvl_e lvl_v [NUM_VEC];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_lvl
    if (v < NUM_XCAP) begin : g_top
      assign lvl_v[v] = hi[v] ? LV_X : LV_L;
    end else begin : g_mid
      assign lvl_v[v] = hi[v] ? LV_H : LV_L;
    end
  end

  // scan from the largest index down; >= lets smaller indices take ties
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = LV_NONE;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (req[v] && lvl_v[v] >= win_lvl) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(v);
        win_lvl   = lvl_v[v];
      end
    end
  end

endmodule

// File: rtl/irq_svc.sv
module irq_svc
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  lvl_e             push_lvl,
  input  logic             pop,
  output logic [LVL_N-1:0] svc,
  output lvl_e             cur_lvl
);

  logic [LVL_N-1:0] svc_q;
  logic [LVL_N-1:0] top_oh;

  always_comb begin
    top_oh  = '0;
    cur_lvl = LV_NONE;
    if (svc_q[2]) begin
      top_oh  = 3'b100;
      cur_lvl = LV_X;
    end else if (svc_q[1]) begin
      top_oh  = 3'b010;
      cur_lvl = LV_H;
    end else if (svc_q[0]) begin
      top_oh  = 3'b001;
      cur_lvl = LV_L;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_q <= '0;
    end else if (pop) begin
      svc_q <= svc_q & ~top_oh;
    end else if (push) begin
      svc_q <= svc_q | lvl_bit(push_lvl);
    end
  end

  assign svc = svc_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int                 NUM_SRC    = 27,
  parameter int                 NUM_VEC    = 10,
  parameter int                 NUM_XCAP   = 2,
  parameter int                 ADDR_W     = 17,
  parameter int                 VEC_BASE   = 3,
  parameter int                 VEC_STRIDE = 8,
  parameter logic [NUM_VEC-1:0] STOP_WAKE  = 10'b10_0000_1111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_VEC-1:0] vec_en,
  input  logic [NUM_VEC-1:0] vec_hi,
  input  logic               gie,
  input  logic               cpu_ready,
  input  logic               reti,
  output logic               take,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [2:0]         in_service,
  output logic               wake_halt,
  output logic               wake_stop
);

  localparam int IDX_W = $clog2(NUM_VEC);

  logic [NUM_VEC-1:0] vec_req;
  logic [NUM_VEC-1:0] pend;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  lvl_e               win_lvl;
  lvl_e               cur_lvl;
  logic               eligible;
  logic               accept;
  logic               take_q;
  logic [ADDR_W-1:0]  addr_q;

  irq_group #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC)) u_group (
    .src_req (src_req),
    .vec_req (vec_req)
  );

  assign pend = vec_req & vec_en;

  irq_pick #(.NUM_VEC(NUM_VEC), .NUM_XCAP(NUM_XCAP)) u_pick (
    .req       (pend),
    .hi        (vec_hi),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  irq_svc u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .push_lvl (win_lvl),
    .pop      (reti),
    .svc      (in_service),
    .cur_lvl  (cur_lvl)
  );

  assign eligible = gie && win_valid && (win_lvl > cur_lvl);
  assign accept   = eligible && cpu_ready && !reti && !take_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      addr_q <= '0;
    end else begin
      take_q <= accept;
      if (accept) begin
        addr_q <= ADDR_W'(VEC_BASE) + ADDR_W'(win_idx) * ADDR_W'(VEC_STRIDE);
      end
    end
  end

  assign take      = take_q;
  assign vec_addr  = addr_q;
  assign wake_halt = eligible;
  assign wake_stop = |(pend & STOP_WAKE);

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int                 NUM_SRC    = 27,
  parameter int                 NUM_VEC    = 10,
  parameter int                 NUM_XCAP   = 2,
  parameter int                 ADDR_W     = 17,
  parameter int                 VEC_BASE   = 3,
  parameter int                 VEC_STRIDE = 8,
  parameter logic [NUM_VEC-1:0] STOP_WAKE  = 10'b10_0000_1111
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_req,
  input logic [NUM_VEC-1:0] vec_en,
  input logic [NUM_VEC-1:0] vec_hi,
  input logic               gie,
  input logic               cpu_ready,
  input logic               reti,
  input logic               take,
  input logic [ADDR_W-1:0]  vec_addr,
  input logic [2:0]         in_service,
  input logic               wake_halt,
  input logic               wake_stop
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(VEC_STRIDE);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(VEC_BASE + VEC_STRIDE * (NUM_VEC - 1));
  localparam logic [ADDR_W-1:0] XLIM_A = ADDR_W'(VEC_BASE + VEC_STRIDE * NUM_XCAP);

  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);  // R7

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> $stable(vec_addr));  // R7

  AST_ADDR_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (vec_addr >= BASE_A && vec_addr <= LAST_A &&
              ((vec_addr - BASE_A) % STEP_A) == '0));  // R2

  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(gie));  // R6

  AST_TAKE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($past(cpu_ready) && !$past(reti)));  // R10

  AST_PUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($countones(in_service) == $countones($past(in_service)) + 1));  // R8

  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && in_service != 3'b000) |=>
      ($countones(in_service) == $countones($past(in_service)) - 1));  // R9

  AST_X_FROM_LOW_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_service[2]) |-> (take && vec_addr < XLIM_A));  // R3

  AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(wake_halt));  // R11

endmodule

bind irq_arbiter irq_arbiter_chk #(
  .NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC), .NUM_XCAP(NUM_XCAP), .ADDR_W(ADDR_W),
  .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE), .STOP_WAKE(STOP_WAKE)
) u_chk (.*);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [26:0] src_req = '0;
  logic [9:0]  vec_en = '1;
  logic [9:0]  vec_hi = '0;
  logic        gie = 1'b1;
  logic        cpu_ready = 1'b1;
  logic        reti = 1'b0;
  logic        take;
  logic [16:0] vec_addr;
  logic [2:0]  in_service;
  logic        wake_halt;
  logic        wake_stop;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench-side reference state
  logic [2:0]  m_svc = '0;
  logic        m_take = 1'b0;
  logic [16:0] m_addr = '0;

  always #2 clk = ~clk;

  irq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .vec_en(vec_en), .vec_hi(vec_hi),
    .gie(gie), .cpu_ready(cpu_ready), .reti(reti), .take(take), .vec_addr(vec_addr),
    .in_service(in_service), .wake_halt(wake_halt), .wake_stop(wake_stop)
  );

  function automatic logic [9:0] f_group(input logic [26:0] s);
    int sz [10] = '{1, 1, 3, 4, 2, 3, 3, 3, 3, 4};
    int lo = 0;
    logic [9:0] r = '0;
    for (int v = 0; v < 10; v++) begin
      for (int k = lo; k < lo + sz[v]; k++) if (s[k]) r[v] = 1'b1;
      lo += sz[v];
    end
    return r;
  endfunction

  function automatic int f_lvl(input int v, input bit hi);
    if (!hi) return 1;
    return (v < 2) ? 3 : 2;
  endfunction

  function automatic int f_cur(input logic [2:0] s);
    if (s[2]) return 3;
    if (s[1]) return 2;
    if (s[0]) return 1;
    return 0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // one clock cycle; inputs were set just after a falling edge
  task automatic cycle();
    logic [9:0] pend;
    int best, idx, cur;
    bit elig, acc;
    pend = f_group(src_req) & vec_en;
    best = 0; idx = 0;
    for (int v = 0; v < 10; v++)
      if (pend[v] && f_lvl(v, vec_hi[v]) > best) begin
        best = f_lvl(v, vec_hi[v]);
        idx = v;
      end
    cur  = f_cur(m_svc);
    elig = gie && (best > cur);
    acc  = elig && cpu_ready && !reti && !m_take;
    #1;
    chk(32'(wake_halt), 32'(elig), "R11 wake_halt");
    chk(32'(wake_stop), 32'(|(pend & 10'b10_0000_1111)), "R12 wake_stop");
    @(posedge clk);
    if (reti) begin
      if (m_svc[2]) m_svc[2] = 1'b0;
      else if (m_svc[1]) m_svc[1] = 1'b0;
      else m_svc[0] = 1'b0;
    end else if (acc) begin
      m_svc[best-1] = 1'b1;
    end
    m_take = acc;
    if (acc) m_addr = 17'(3 + 8 * idx);
    #1;
    chk(32'(take), 32'(m_take), "R7 take");
    chk(32'(vec_addr), 32'(m_addr), "R2 vec_addr");
    chk(32'(in_service), 32'(m_svc), "R8 in_service");
    @(negedge clk);
  endtask

  task automatic drain();
    src_req = '0;
    repeat (3) begin
      reti = 1'b1;
      cycle();
    end
    reti = 1'b0;
    cycle();
    vec_en = '1; vec_hi = '0; gie = 1'b1; cpu_ready = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(32'(take), 0, "R13 reset take");
    chk(32'(vec_addr), 0, "R13 reset vec_addr");
    chk(32'(in_service), 0, "R13 reset in_service");
    @(negedge clk);
    rst_n = 1'b1;
    cycle();

    // R1 R2: last source maps to vector 9
    src_req = 27'(1) << 26;
    cycle();
    chk(32'(take), 1, "R1 take from source 26");
    chk(32'(vec_addr), 32'h4B, "R2 vector 9 address");
    drain();

    // R4: equal L levels, smaller index wins
    src_req = (27'(1) << 2) | (27'(1) << 11);
    cycle();
    chk(32'(vec_addr), 32'h13, "R4 tie to smaller index");
    drain();

    // R3 R4: H on vector 9 beats L on vector 0
    vec_hi[9] = 1'b1;
    src_req = (27'(1) << 23) | 27'(1);
    cycle();
    chk(32'(vec_addr), 32'h4B, "R4 higher level wins");
    chk(32'(in_service), 32'b010, "R3 H level set");
    src_req = '0;
    cycle();

    // R5: another H is blocked while H in service
    vec_hi[4] = 1'b1;
    src_req = 27'(1) << 9;
    repeat (3) begin
      cycle();
      chk(32'(take), 0, "R5 equal level blocked");
    end
    // R3: vector 0 at X nests above H
    vec_hi[0] = 1'b1;
    src_req = 27'(1);
    cycle();
    chk(32'(vec_addr), 32'h03, "R3 X vector accepted");
    chk(32'(in_service), 32'b110, "R3 X bit set");
    src_req = '0;
    reti = 1'b1;
    cycle();
    chk(32'(in_service), 32'b010, "R9 pop X first");
    cycle();
    chk(32'(in_service), 32'b000, "R9 pop H next");
    // R9: request present during reti is not accepted
    src_req = 27'(1) << 14;
    cycle();
    chk(32'(take), 0, "R9 no accept with reti");
    reti = 1'b0;
    cycle();
    chk(32'(vec_addr), 32'h33, "R9 accepted after reti");
    drain();

    // R6 R12: global enable off
    gie = 1'b0;
    src_req = 27'(1);
    cycle();
    chk(32'(take), 0, "R6 gie off");
    chk(32'(wake_stop), 1, "R12 stop wake without gie");
    gie = 1'b1;
    vec_en[0] = 1'b0;
    vec_hi[0] = 1'b1;
    cycle();
    chk(32'(take), 0, "R6 vector disabled");
    chk(32'(wake_stop), 0, "R12 disabled vector no wake");
    src_req = 27'b11;
    cycle();
    chk(32'(vec_addr), 32'h0B, "R6 disabled vector cannot win");
    drain();
    src_req = 27'(1) << 14;
    cycle();
    chk(32'(wake_stop), 0, "R12 vector 6 not in stop set");
    drain();

    // R10: core not ready
    cpu_ready = 1'b0;
    src_req = 27'(1) << 17;
    cycle();
    chk(32'(take), 0, "R10 not ready");
    chk(32'(wake_halt), 1, "R11 halt wake while not ready");
    cpu_ready = 1'b1;
    cycle();
    chk(32'(vec_addr), 32'h3B, "R10 accepted when ready");
    drain();

    // R7: no accept in the cycle that carries take
    src_req = 27'(1) << 20;
    cycle();
    chk(32'(take), 1, "R7 first take");
    vec_hi[0] = 1'b1;
    src_req = 27'(1);
    cycle();
    chk(32'(take), 0, "R7 gap after take");
    cycle();
    chk(32'(vec_addr), 32'h03, "R7 nested take after gap");
    drain();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [26:0] s;
      s = '0;
      for (int b = 0; b < 27; b++) if ($urandom % 20 == 0) s[b] = 1'b1;
      src_req = s;
      if (n % 40 == 0) begin
        vec_hi = 10'($urandom);
        for (int b = 0; b < 10; b++) vec_en[b] = ($urandom % 10) != 0;
      end
      gie = ($urandom % 20) != 0;
      cpu_ready = ($urandom % 7) != 0;
      reti = ($urandom % 9) == 0;
      cycle();
    end

    done = 1;
    finish_run();
  end

endmodule